// File: doc/BRIEF.md
# USB Token Packet Receiver

This block takes a single-ended receive line that an upstream stage has already sampled once per bit period, and turns a token packet on it into a decoded command. A one-cycle `bit_valid` strobe marks each sampled bit. Each sample is NRZI-decoded. The start pattern is found by a simple match, and stuffed bits are removed. The remaining 24 bits are split into the packet identifier, the 7-bit device address, the 4-bit endpoint and the 5-bit checksum.

The identifier must carry its own inverted copy and must name a token kind. The checksum register must land on its fixed residual. The address must match the device address that the system has programmed on `dev_addr`. When all of these hold, the block raises `tok_valid` for one cycle and presents the token type and the endpoint. A framing or integrity fault raises `tok_err` for one cycle instead. A well-formed token meant for another device is dropped with no pulse at all. Clock recovery, end-of-packet detection and data packets are handled elsewhere.

Top module: `usbtok_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tok_valid` and `tok_err` are low; the line decoder assumes an idle high level.
- R2: Decoding is NRZI, sampled only when `bit_valid` is high: a sample equal to the previous sample is a 1, and a level change is a 0.
- R3: A packet starts only after the decoded sequence of seven 0s followed by one 1. Any other pattern, such as six 0s and then a 1, or an idle line, produces no pulse.
- R4: Bits arrive least significant first. The fields arrive in this order: type nibble (4 bits), check nibble (4 bits), address (7 bits), endpoint (4 bits), checksum (5 bits). `tok_pid` shows the type nibble and `tok_endp` shows the endpoint of an accepted token.
- R5: The run counter starts at 1 on the final 1 of the start pattern. After six consecutive decoded 1s, the next bit is discarded and not counted as data.
- R6: If the bit that follows six 1s is a 1, `tok_err` pulses in the cycle after that sample and the packet is abandoned.
- R7: A packet whose check nibble is not the bitwise inverse of its type nibble raises `tok_err`.
- R8: Only type nibbles 0001 (OUT), 1001 (IN) and 1101 (SETUP) are accepted. A well-formed identifier with any other type raises `tok_err`.
- R9: The checksum uses x^5+x^2+1, preset to 11111, over the 11 address and endpoint bits. The sender transmits the inverted remainder, highest-order bit first. Feeding all 16 bits must leave 01100, or `tok_err` pulses.
- R10: A token that passes every check but whose address differs from `dev_addr` produces neither `tok_valid` nor `tok_err`.
- R11: `tok_valid` and `tok_err` are single-cycle pulses and never high together. A checked result appears two clock cycles after the strobe of the final checksum bit.
- R12: Endpoint 0 is accepted like any other endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One-cycle strobe per sampled bit |
| rx_line | input | 1 | Sampled single-ended line level |
| dev_addr | input | 7 | Programmed device address |
| tok_valid | output | 1 | Accepted-token pulse |
| tok_err | output | 1 | Packet fault pulse |
| tok_pid | output | 4 | Type nibble of the last accepted token |
| tok_endp | output | 4 | Endpoint of the last accepted token |

## Verification
Suppose the run counter or the shift register drifts by one bit. Every later field then moves, so the checksum residual misses and the next token shows up as a `tok_err` pulse instead of a `tok_valid`, two cycles after its last bit. If the decoder's stored level is wrong, the start pattern never matches, and a missing pulse is caught when the expected-result queue is still non-empty at the end. A flaw in the stuffing logic shows only on tokens that contain long runs of 1s, so the all-ones address and endpoint token and a deliberately broken stuff bit are both driven.

// File: rtl/usbtok_pkg.sv
package usbtok_pkg;

    localparam int PID_W   = 4;
    localparam int ADDR_W  = 7;
    localparam int ENDP_W  = 4;
    localparam int CRC_W   = 5;
    localparam int SYNC_W  = 8;

    localparam int HDR_BITS = 2 * PID_W + ADDR_W + ENDP_W;
    localparam int TOK_BITS = HDR_BITS + CRC_W;

    // newest decoded bit sits in the MSB: seven 0s then a final 1
    localparam logic [SYNC_W-1:0] SYNC_PAT = 8'h80;

    localparam logic [CRC_W-1:0] CRC_POLY     = 5'b00101;
    localparam logic [CRC_W-1:0] CRC_PRESET   = 5'b11111;
    localparam logic [CRC_W-1:0] CRC_RESIDUAL = 5'b01100;

    localparam logic [PID_W-1:0] PID_OUT   = 4'b0001;
    localparam logic [PID_W-1:0] PID_IN    = 4'b1001;
    localparam logic [PID_W-1:0] PID_SETUP = 4'b1101;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_CHECK = 2'd2
    } rx_state_e;

    // header as held in the shift register (first received bit at LSB)
    typedef struct packed {
        logic [ENDP_W-1:0] endp;
        logic [ADDR_W-1:0] addr;
        logic [PID_W-1:0]  pid_chk;
        logic [PID_W-1:0]  pid_type;
    } tok_hdr_t;

    function automatic logic is_token(input logic [PID_W-1:0] t);
        return (t == PID_OUT) || (t == PID_IN) || (t == PID_SETUP);
    endfunction

endpackage

// File: rtl/usbtok_nrzi.sv
module usbtok_nrzi (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic line,
    output logic dbit
);
    logic prev_q;

    // unchanged level decodes to 1, a transition to 0
    assign dbit = (line == prev_q);

    always_ff @(posedge clk) begin
        if (rst)      prev_q <= 1'b1;
        else if (stb) prev_q <= line;
    end
endmodule

// File: rtl/usbtok_unstuff.sv
module usbtok_unstuff #(
    parameter int RUN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic din,
    input  logic en,
    input  logic load,
    output logic keep,
    output logic err
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones_q;
    logic          at_limit;

    assign at_limit = (ones_q == CW'(RUN));
    assign keep     = stb && en && !at_limit;
    assign err      = stb && en && at_limit && din;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (load) begin
            ones_q <= CW'(1);
        end else if (stb && en) begin
            if (at_limit)  ones_q <= '0;
            else if (din)  ones_q <= ones_q + CW'(1);
            else           ones_q <= '0;
        end
    end
endmodule

// File: rtl/usbtok_crc.sv
module usbtok_crc #(
    parameter int            W      = 5,
    parameter logic [W-1:0]  POLY   = 5'b00101,
    parameter logic [W-1:0]  PRESET = 5'b11111
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = din ^ crc[W-1];
        nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || init) crc <= PRESET;
        else if (en)     crc <= nxt;
    end
endmodule

// File: rtl/usbtok_rx.sv
module usbtok_rx
    import usbtok_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              rx_line,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              tok_valid,
    output logic              tok_err,
    output logic [PID_W-1:0]  tok_pid,
    output logic [ENDP_W-1:0] tok_endp
);
    localparam int CNT_W = $clog2(TOK_BITS + 1);

    rx_state_e           state_q;
    logic [SYNC_W-1:0]   hist_q;
    logic [SYNC_W-1:0]   hist_nxt;
    logic [HDR_BITS-1:0] sh_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CRC_W-1:0]    crc_q;
    logic                dbit;
    logic                keep;
    logic                stuff_err;
    logic                sync_hit;
    logic                crc_en;
    tok_hdr_t            hdr;
    logic                pid_ok;
    logic                type_ok;
    logic                crc_ok;
    logic                addr_hit;

    usbtok_nrzi u_nrzi (
        .clk  (clk),
        .rst  (rst),
        .stb  (bit_valid),
        .line (rx_line),
        .dbit (dbit)
    );

    usbtok_unstuff #(.RUN(STUFF_RUN)) u_unstuff (
        .clk  (clk),
        .rst  (rst),
        .stb  (bit_valid),
        .din  (dbit),
        .en   (state_q == ST_RECV),
        .load (sync_hit),
        .keep (keep),
        .err  (stuff_err)
    );

    usbtok_crc #(.W(CRC_W), .POLY(CRC_POLY), .PRESET(CRC_PRESET)) u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (sync_hit),
        .en   (crc_en),
        .din  (dbit),
        .crc  (crc_q)
    );

    always_comb begin
        hist_nxt = {dbit, hist_q[SYNC_W-1:1]};
        sync_hit = (state_q == ST_IDLE) && bit_valid && (hist_nxt == SYNC_PAT);
        crc_en   = keep && (cnt_q >= CNT_W'(2 * PID_W));
        hdr      = tok_hdr_t'(sh_q);
        pid_ok   = (hdr.pid_chk == ~hdr.pid_type);
        type_ok  = is_token(hdr.pid_type);
        crc_ok   = (crc_q == CRC_RESIDUAL);
        addr_hit = (hdr.addr == dev_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            hist_q    <= '1;
            sh_q      <= '0;
            cnt_q     <= '0;
            tok_valid <= 1'b0;
            tok_err   <= 1'b0;
            tok_pid   <= '0;
            tok_endp  <= '0;
        end else begin
            tok_valid <= 1'b0;
            tok_err   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (bit_valid) begin
                        hist_q <= sync_hit ? '1 : hist_nxt;
                        if (sync_hit) begin
                            state_q <= ST_RECV;
                            cnt_q   <= '0;
                        end
                    end
                end
                ST_RECV: begin
                    if (stuff_err) begin
                        tok_err <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (keep) begin
                        if (cnt_q < CNT_W'(HDR_BITS))
                            sh_q <= {dbit, sh_q[HDR_BITS-1:1]};
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(TOK_BITS - 1))
                            state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    state_q <= ST_IDLE;
                    if (!pid_ok || !type_ok || !crc_ok) begin
                        tok_err <= 1'b1;
                    end else if (addr_hit) begin
                        tok_valid <= 1'b1;
                        tok_pid   <= hdr.pid_type;
                        tok_endp  <= hdr.endp;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbtok_rx_checker.sv
module usbtok_rx_checker
    import usbtok_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_valid,
    input logic             tok_valid,
    input logic             tok_err,
    input logic [PID_W-1:0] tok_pid,
    input rx_state_e        state_q
);
    p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tok_valid && !tok_err));

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(tok_valid && tok_err));

    p_vpulse_r11: assert property (@(posedge clk) disable iff (rst)
        tok_valid |=> !tok_valid);

    p_epulse_r11: assert property (@(posedge clk) disable iff (rst)
        tok_err |=> !tok_err);

    p_vsrc_r11: assert property (@(posedge clk) disable iff (rst)
        tok_valid |-> ($past(state_q) == ST_CHECK));

    p_type_r8: assert property (@(posedge clk) disable iff (rst)
        tok_valid |-> is_token(tok_pid));

    p_esrc_r6: assert property (@(posedge clk) disable iff (rst)
        tok_err |-> (($past(state_q) == ST_CHECK) ||
                     ($past(state_q) == ST_RECV && $past(bit_valid))));
endmodule

bind usbtok_rx usbtok_rx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .tok_valid (tok_valid),
    .tok_err   (tok_err),
    .tok_pid   (tok_pid),
    .state_q   (state_q)
);

// File: tb/usbtok_rx_test.sv
module usbtok_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0;
    logic       rx_line = 1'b1;
    logic [6:0] dev_addr = 7'd0;
    logic       tok_valid;
    logic       tok_err;
    logic [3:0] tok_pid;
    logic [3:0] tok_endp;

    usbtok_rx uut (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .rx_line   (rx_line),
        .dev_addr  (dev_addr),
        .tok_valid (tok_valid),
        .tok_err   (tok_err),
        .tok_pid   (tok_pid),
        .tok_endp  (tok_endp)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit         is_err;
        logic [3:0] pid;
        logic [3:0] endp;
        int         lat;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   last_cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   pulses = 0;
    logic lvl = 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (tok_valid || tok_err)) begin
            pulses++;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R10/R3: unexpected pulse valid=%0b err=%0b, expected none",
                         tok_valid, tok_err);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (tok_err !== e.is_err || tok_valid !== !e.is_err) begin
                    fails++;
                    $display("FAIL %s: actual valid=%0b err=%0b, expected err=%0b",
                             e.req, tok_valid, tok_err, e.is_err);
                end else if (!e.is_err && (tok_pid !== e.pid || tok_endp !== e.endp)) begin
                    fails++;
                    $display("FAIL %s: actual pid=%h endp=%h, expected pid=%h endp=%h",
                             e.req, tok_pid, tok_endp, e.pid, e.endp);
                end
                checks++;
                if (cyc != last_cyc + e.lat) begin
                    fails++;
                    $display("FAIL R11 (%s): pulse at cycle %0d, expected %0d",
                             e.req, cyc, last_cyc + e.lat);
                end
            end
        end
    end

    task automatic tx_level(input logic lv, input bit mark);
        @(negedge clk);
        rx_line   = lv;
        bit_valid = 1'b1;
        if (mark) last_cyc = cyc;
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_dbit(input logic b, input bit mark);
        if (!b) lvl = ~lvl;
        tx_level(lvl, mark);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tx_dbit(1'b1, 1'b0);
    endtask

    task automatic push(input bit is_err, input logic [3:0] pid, input logic [3:0] endp,
                        input int lat, input string req);
        exp_t e;
        e.is_err = is_err; e.pid = pid; e.endp = endp; e.lat = lat; e.req = req;
        q.push_back(e);
    endtask

    task automatic send_tok(input logic [7:0] pid8, input logic [6:0] addr,
                            input logic [3:0] endp, input bit crc_flip, input bit bad_stuff);
        logic [4:0]  c;
        logic [10:0] data;
        logic [23:0] bits;
        logic        fb;
        int          ones;
        data = {endp, addr};
        c = 5'b11111;
        for (int i = 0; i < 11; i++) begin
            fb = data[i] ^ c[4];
            c  = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
        end
        bits[7:0]   = pid8;
        bits[14:8]  = addr;
        bits[18:15] = endp;
        for (int i = 0; i < 5; i++) bits[19+i] = ~c[4-i];
        if (crc_flip) bits[19] = ~bits[19];
        for (int i = 0; i < 7; i++) tx_dbit(1'b0, 1'b0);
        tx_dbit(1'b1, 1'b0);
        ones = 1;
        for (int i = 0; i < 24; i++) begin
            tx_dbit(bits[i], 1'b1);
            ones = bits[i] ? ones + 1 : 0;
            if (ones == 6) begin
                if (bad_stuff) begin
                    tx_dbit(1'b1, 1'b1);
                    return;
                end
                tx_dbit(1'b0, 1'b0);
                ones = 0;
            end
        end
    endtask

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        checks++;
        if (tok_valid !== 1'b0 || tok_err !== 1'b0) begin
            fails++;
            $display("FAIL R1: in reset valid=%0b err=%0b, expected 0 0", tok_valid, tok_err);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (tok_valid !== 1'b0 || tok_err !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset valid=%0b err=%0b, expected 0 0", tok_valid, tok_err);
        end

        // R3: idle and a short start pattern give nothing
        p0 = pulses;
        idle(20);
        for (int i = 0; i < 6; i++) tx_dbit(1'b0, 1'b0);
        tx_dbit(1'b1, 1'b0);
        idle(30);
        checks++;
        if (pulses != p0) begin
            fails++;
            $display("FAIL R3: %0d pulses after false start, expected 0", pulses - p0);
        end

        // R2, R4: OUT token, address 5, endpoint 3
        dev_addr = 7'h05;
        push(0, 4'b0001, 4'h3, 2, "R2/R4 OUT token");
        send_tok(8'hE1, 7'h05, 4'h3, 0, 0);
        idle(10);

        // R5: IN token, all-ones address and endpoint force stuffing
        dev_addr = 7'h7F;
        push(0, 4'b1001, 4'hF, 2, "R5 stuffed IN token");
        send_tok(8'h69, 7'h7F, 4'hF, 0, 0);
        idle(10);

        // R12: SETUP to endpoint 0
        dev_addr = 7'h2A;
        push(0, 4'b1101, 4'h0, 2, "R12 SETUP endpoint 0");
        send_tok(8'h2D, 7'h2A, 4'h0, 0, 0);
        idle(10);

        // R6: broken stuff bit
        dev_addr = 7'h7F;
        push(1, 4'h0, 4'h0, 1, "R6 stuff error");
        send_tok(8'h69, 7'h7F, 4'hF, 0, 1);
        idle(12);

        // R7: check nibble not inverse of type
        dev_addr = 7'h05;
        push(1, 4'h0, 4'h0, 2, "R7 bad check nibble");
        send_tok(8'h79, 7'h05, 4'h3, 0, 0);
        idle(10);

        // R8: well-formed but non-token type
        push(1, 4'h0, 4'h0, 2, "R8 non-token type");
        send_tok(8'hC3, 7'h05, 4'h3, 0, 0);
        idle(10);

        // R9: corrupted checksum
        push(1, 4'h0, 4'h0, 2, "R9 checksum residual");
        send_tok(8'hE1, 7'h05, 4'h3, 1, 0);
        idle(10);

        // R10: other device's token is dropped silently
        p0 = pulses;
        send_tok(8'h69, 7'h06, 4'h2, 0, 0);
        idle(10);
        checks++;
        if (pulses != p0) begin
            fails++;
            $display("FAIL R10: %0d pulses for foreign address, expected 0", pulses - p0);
        end
        push(0, 4'b0001, 4'h9, 2, "R10 next own token");
        send_tok(8'hE1, 7'h05, 4'h9, 0, 0);
        idle(10);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R11: %0d expected results never appeared, expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule